// File: doc/BRIEF.md
# Output Driver Impedance Code Updater

This block owns the code word that sets the strength of a set of output drivers. A measurement circuit outside the block presents a desired code. Another input says that the calibration resistor is missing or pulled to the I/O supply. The block walks its applied code toward the desired value one step at a time. It changes the applied code only in clock cycles where the data outputs are in high impedance, so a driver that is pushing a value never sees its strength change mid-bit.

Code 0 is the strongest setting, which is the lowest impedance. The all-ones code is the weakest setting, which is the highest impedance.

Moves are paced by a timer that runs on every clock. A step is allowed only once the timer has counted `STEP_GAP = SETTLE_CYCLES >> CODE_W` cycles since the previous step. This spacing means a move across the full code range, made while the outputs stay in high impedance, finishes within `SETTLE_CYCLES` clocks.

The desired code is registered every cycle. A value that arrives while the drivers are active therefore waits in that register and is picked up at the next high-impedance window.

Top module: `drv_imp_updater`

## Requirements
- R1: While reset is asserted and right after it is released, `applied_code` is 0 (the minimum-impedance code) and `done` is 1.
- R2: `applied_code` changes only at a rising edge where `hiz` was sampled 1. While `hiz` is 0 the code holds its value.
- R3: At any one edge, `applied_code` changes by exactly one code step or not at all, and each step moves it toward the registered target.
- R4: While `cal_open` is 1, the registered target becomes the all-ones code one edge later, whatever `target_code` is.
- R5: Consecutive steps are at least `STEP_GAP` edges apart. Suppose `hiz` stays 1 and the timer is already full, and a new target is presented that is n ≥ 1 codes away. Then the code reaches that target on the edge numbered (n-1)*`STEP_GAP`+2, counting from the first edge after the new target is presented.
- R6: If `hiz` stays 1 from the release of reset, a move from code 0 to the all-ones code completes within `SETTLE_CYCLES` edges.
- R7: If `target_code` changes one or more times while `hiz` is 0, the code does not move. When a window opens, the code moves to the last value presented.
- R8: `done` is 1 exactly when `applied_code` equals the registered target. The registered target is the target input as it stood one edge earlier.
- R9: With the timer full, a single-cycle high-impedance window moves the code by exactly one step and no more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_code | input | CODE_W | Desired impedance code from the measurement circuit |
| cal_open | input | 1 | 1 when the calibration resistor is absent or tied high; forces the all-ones target |
| hiz | input | 1 | 1 in a cycle where the data outputs are in high impedance |
| applied_code | output | CODE_W | Code currently applied to the drivers |
| done | output | 1 | Applied code equals the registered target |

## Verification
Two kinds of internal fault show up at `applied_code`.

A pacing timer that runs fast or slow shows up as a convergence edge count that is off from (n-1)*STEP_GAP+2. This is visible at the edge where the code lands, on the very first move that spans two or more steps.

A faulty gate on the update window shows up as a code that moves while `hiz` is low. A faulty direction or step choice shows up as a jump larger than one code, or as a step away from the target. Either fault is visible one edge after it happens.

A target register that is stale or not forced shows up as `done` disagreeing with the code, or as convergence to the wrong value. This appears within one move.

// File: rtl/drv_imp_pkg.sv
package drv_imp_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/drv_imp_target.sv
module drv_imp_target #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] raw_code,
    input  logic              force_weak,
    output logic [CODE_W-1:0] eff_code
);
    localparam logic [CODE_W-1:0] WEAKEST = '1;

    always_comb begin
        eff_code = force_weak ? WEAKEST : raw_code;
    end
endmodule

// File: rtl/drv_imp_pacer.sv
module drv_imp_pacer #(
    parameter int STEP_GAP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic ready
);
    localparam int PACE_W = (STEP_GAP > 1) ? $clog2(STEP_GAP) : 1;
    localparam logic [PACE_W-1:0] LIMIT = PACE_W'(STEP_GAP - 1);

    typedef struct packed {
        logic [PACE_W-1:0] cnt;
    } pace_t;

    pace_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clear) begin
            p_d.cnt = '0;
        end else if (p_q.cnt != LIMIT) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign ready = (p_q.cnt == LIMIT);
endmodule

// File: rtl/drv_imp_stepper.sv
module drv_imp_stepper
    import drv_imp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] cur_code,
    input  logic [CODE_W-1:0] goal_code,
    input  logic              window,
    input  logic              pace_ok,
    output logic [CODE_W-1:0] next_code,
    output logic              stepped,
    output step_dir_e         dir
);
    always_comb begin
        dir       = DIR_HOLD;
        next_code = cur_code;
        if (window && pace_ok) begin
            if (goal_code > cur_code) begin
                dir = DIR_UP;
            end else if (goal_code < cur_code) begin
                dir = DIR_DOWN;
            end
        end
        case (dir)
            DIR_UP:   next_code = cur_code + 1'b1;
            DIR_DOWN: next_code = cur_code - 1'b1;
            default:  next_code = cur_code;
        endcase
        stepped = (dir != DIR_HOLD);
    end
endmodule

// File: rtl/drv_imp_updater.sv
module drv_imp_updater
    import drv_imp_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int SETTLE_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] target_code,
    input  logic              cal_open,
    input  logic              hiz,
    output logic [CODE_W-1:0] applied_code,
    output logic              done
);
    localparam int STEP_GAP_RAW = SETTLE_CYCLES >> CODE_W;
    localparam int STEP_GAP     = (STEP_GAP_RAW > 0) ? STEP_GAP_RAW : 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] tgt;
    } upd_state_t;

    upd_state_t r_d, r_q;

    logic [CODE_W-1:0] eff_target;
    logic [CODE_W-1:0] stepped_code;
    logic              step_taken;
    logic              pace_ready;
    step_dir_e         step_dir;
    logic [CODE_W-1:0] held_target;

    drv_imp_target #(.CODE_W(CODE_W)) u_target (
        .raw_code   (target_code),
        .force_weak (cal_open),
        .eff_code   (eff_target)
    );

    drv_imp_pacer #(.STEP_GAP(STEP_GAP)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (step_taken),
        .ready (pace_ready)
    );

    drv_imp_stepper #(.CODE_W(CODE_W)) u_stepper (
        .cur_code  (r_q.code),
        .goal_code (r_q.tgt),
        .window    (hiz),
        .pace_ok   (pace_ready),
        .next_code (stepped_code),
        .stepped   (step_taken),
        .dir       (step_dir)
    );

    always_comb begin
        r_d      = r_q;
        r_d.tgt  = eff_target;
        r_d.code = stepped_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign held_target  = r_q.tgt;
    assign applied_code = r_q.code;
    assign done         = (r_q.code == r_q.tgt);
endmodule

// File: rtl/drv_imp_updater_chk.sv
module drv_imp_updater_chk #(
    parameter int CODE_W   = 6,
    parameter int STEP_GAP = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hiz,
    input logic              cal_open,
    input logic [CODE_W-1:0] applied_code,
    input logic [CODE_W-1:0] held_target
);
    logic [CODE_W-1:0] prev_q;
    int unsigned       gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            gap_q  <= 0;
        end else begin
            prev_q <= applied_code;
            if (applied_code != prev_q) begin
                gap_q <= 0;
            end else if (gap_q < STEP_GAP) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    // R2
    hold_when_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz |=> $stable(applied_code));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_code != prev_q) |->
            ((int'(applied_code) - int'(prev_q) == 1) || (int'(prev_q) - int'(applied_code) == 1)));

    // R3
    toward_goal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_code > prev_q) |-> ($past(held_target) > prev_q));

    // R4
    forced_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_open |=> (held_target == {CODE_W{1'b1}}));

    // R5
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (applied_code != prev_q) |-> (gap_q >= STEP_GAP - 1));
endmodule

bind drv_imp_updater drv_imp_updater_chk #(.CODE_W(CODE_W), .STEP_GAP(STEP_GAP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hiz          (hiz),
    .cal_open     (cal_open),
    .applied_code (applied_code),
    .held_target  (held_target)
);

// File: tb/drv_imp_updater_test.sv
`timescale 1ns/1ps
module drv_imp_updater_test;
    localparam int W      = 4;
    localparam int SETTLE = 64;
    localparam int GAP    = SETTLE >> W;
    localparam int TOP    = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] target_code = '0;
    logic         cal_open = 1'b0;
    logic         hiz = 1'b0;
    logic [W-1:0] applied_code;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    drv_imp_updater #(.CODE_W(W), .SETTLE_CYCLES(SETTLE)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .target_code  (target_code),
        .cal_open     (cal_open),
        .hiz          (hiz),
        .applied_code (applied_code),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_to(input int v);
        target_code = W'(v);
        hiz = 1'b1;
        for (int i = 0; i < 200 && applied_code != W'(v); i++) tick();
    endtask

    initial begin
        @(negedge clk);
        check(applied_code == 0, "R1 code in reset", applied_code, 0);
        tick();
        rst_n = 1'b1;
        check(applied_code == 0, "R1 code after reset", applied_code, 0);
        check(done == 1'b1, "R1 done after reset", done, 1);

        // R6: full range from reset with a continuous window
        begin
            int edges = 0;
            target_code = W'(TOP);
            hiz = 1'b1;
            while (applied_code != W'(TOP) && edges < 4 * SETTLE) begin
                tick();
                edges++;
            end
            check(edges <= SETTLE, "R6 full range edges", edges, SETTLE);
        end

        // R5 R3 R8: sweep all start/target pairs
        for (int a = 0; a <= TOP; a++) begin
            for (int b = 0; b <= TOP; b++) begin
                int n;
                int edges;
                int prev;
                bit bad_step;
                settle_to(a);
                for (int i = 0; i < GAP + 2; i++) tick();
                n = (a > b) ? a - b : b - a;
                target_code = W'(b);
                edges = 0;
                prev = applied_code;
                bad_step = 1'b0;
                while (applied_code != W'(b) && edges < 200) begin
                    tick();
                    edges++;
                    if (applied_code != W'(prev)) begin
                        if (!((b > prev && applied_code == W'(prev + 1)) ||
                              (b < prev && applied_code == W'(prev - 1)))) bad_step = 1'b1;
                    end
                    if (edges == 1 && n > 1) check(done == 1'b0, "R8 done low while moving", done, 0);
                    prev = applied_code;
                end
                check(!bad_step, "R3 single step toward target", applied_code, b);
                if (n > 0) check(edges == (n - 1) * GAP + 2, "R5 convergence edges", edges, (n - 1) * GAP + 2);
                check(done == 1'b1, "R8 done at target", done, 1);
            end
        end

        // R7 R2: targets change while driven; only last one applied later
        begin
            bit moved = 1'b0;
            bit overshoot = 1'b0;
            settle_to(0);
            hiz = 1'b0;
            target_code = 4'd5;
            for (int i = 0; i < 10; i++) begin tick(); if (applied_code != 0) moved = 1'b1; end
            target_code = 4'd9;
            for (int i = 0; i < 10; i++) begin tick(); if (applied_code != 0) moved = 1'b1; end
            target_code = 4'd3;
            for (int i = 0; i < 10; i++) begin tick(); if (applied_code != 0) moved = 1'b1; end
            check(!moved, "R2 code held while driven", applied_code, 0);
            hiz = 1'b1;
            for (int i = 0; i < 40; i++) begin tick(); if (applied_code > 3) overshoot = 1'b1; end
            check(!overshoot, "R7 no move toward stale targets", applied_code, 3);
            check(applied_code == 3, "R7 last target applied", applied_code, 3);
        end

        // R9: single-cycle windows, one step each
        settle_to(3);
        hiz = 1'b0;
        target_code = 4'd10;
        for (int i = 0; i < 10; i++) tick();
        hiz = 1'b1;
        tick();
        hiz = 1'b0;
        for (int i = 0; i < 10; i++) tick();
        check(applied_code == 4, "R9 first pulse", applied_code, 4);
        hiz = 1'b1;
        tick();
        hiz = 1'b0;
        for (int i = 0; i < 10; i++) tick();
        check(applied_code == 5, "R9 second pulse", applied_code, 5);

        // R4: open calibration pin forces weakest code
        settle_to(2);
        cal_open = 1'b1;
        target_code = 4'd2;
        for (int i = 0; i < 100; i++) tick();
        check(applied_code == TOP, "R4 forced weakest", applied_code, TOP);
        check(done == 1'b1, "R4 done when forced", done, 1);
        cal_open = 1'b0;
        for (int i = 0; i < 100; i++) tick();
        check(applied_code == 2, "R4 release returns", applied_code, 2);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule